// File: doc/BRIEF.md
# Two-Word Burst Double-Data-Rate SRAM Core

This block is an on-chip static memory with a double-data-rate style command and data interface and a fixed burst length of two words. One command is sampled on each rising edge of the single clock. A command is an active-low load strobe, an active-low read/write select and a word address. Every access moves two words: the word at the loaded address and its partner, whose address differs only in bit 0.

Each half of a data cycle is modelled as an explicit slot, so the block needs only one clock domain. A "rise" slot stands for the first half-cycle and a "fall" slot for the second. Write data for a burst is presented on the two write slots in the cycle after the command. Read data is returned on the two read slots one cycle after the command has been captured, which is one and a half data-clock cycles of latency in the original double-rate view. Each read slot has an output-enable flag, so the tri-state driver of a pad ring can be built directly on top of the block. A free-running echo indicator toggles every cycle, so a receiver can tell the read slots apart.

Top module: `ddr2b_core`

## Requirements
- R1: After reset, both output enables are low, both read slots are zero and the echo indicator is low.
- R2: A cycle with `ld_n` high is a no-operation: the memory is not written, and two edges later no read data is driven.
- R3: With `ld_n` low, `rw_n` high starts a read burst and `rw_n` low starts a write burst. A write burst never raises the output enables.
- R4: A burst covers the loaded address A first and then A with bit 0 inverted: an even A is followed by A+1, and an odd A is followed by A-1.
- R5: For a write command sampled at edge n, `wd_rise` is stored at A and `wd_fall` at A^1, both sampled at edge n+1. The values on these ports at any other edge are ignored.
- R6: For a read command sampled at edge n, both output enables are high between edge n+1 and edge n+2. In that window, `q_rise` carries the word at A and `q_fall` carries the word at A^1.
- R7: In a cycle where no read data is due, both output enables are low and both read slots are zero.
- R8: Reads sampled at consecutive edges keep the output enables high for consecutive cycles, giving an unbroken data stream.
- R9: A read sampled on the edge right after a write to the same pair returns the newly written words.
- R10: Once out of reset, the echo indicator inverts on every clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ld_n | input | 1 | Active-low command load strobe |
| rw_n | input | 1 | Read (high) or write (low) select, used while ld_n is low |
| addr | input | AW | Word address of the first burst word |
| wd_rise | input | DW | Write data, first half-cycle slot |
| wd_fall | input | DW | Write data, second half-cycle slot |
| q_rise | output | DW | Read data, first half-cycle slot |
| q_fall | output | DW | Read data, second half-cycle slot |
| q_oe_rise | output | 1 | Output enable for the first read slot |
| q_oe_fall | output | 1 | Output enable for the second read slot |
| echo_ck | output | 1 | Free-running echo phase indicator |

## Verification
For a command sampled at edge n, write data is due at edge n+1, and read data and enables are valid from edge n+1 to edge n+2. The echo indicator changes at every edge. The bench drives and samples on the falling edge. At each falling edge it first checks the outputs against an expectation built one step earlier from the command two steps back. It then forms the expectation for the previous command from a reference array before applying that command's write. This places a same-pair write followed by a read in the right order. Directed sequences cover even and odd start addresses, back-to-back reads, a read right after a write, and no-operation cycles with junk on the inputs. These are followed by seeded random traffic.

// File: rtl/ddr2b_pkg.sv
package ddr2b_pkg;
  typedef enum logic [1:0] {
    OP_NOP = 2'd0,
    OP_RD  = 2'd1,
    OP_WR  = 2'd2
  } op_e;
endpackage

// File: rtl/ddr2b_rst_sync.sv
module ddr2b_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_s = chain_q[STAGES-1];
endmodule

// File: rtl/ddr2b_cmd_dec.sv
module ddr2b_cmd_dec
  import ddr2b_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_s,
  input  logic          ld_n,
  input  logic          rw_n,
  input  logic [AW-1:0] addr,
  output op_e           op_q,
  output logic [AW-1:0] addr_q
);
  op_e           op_d;
  logic [AW-1:0] addr_d;
  logic          addr_en;

  always_comb begin
    addr_en = !ld_n;
    addr_d  = addr;
    if (ld_n)      op_d = OP_NOP;
    else if (rw_n) op_d = OP_RD;
    else           op_d = OP_WR;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      op_q   <= OP_NOP;
      addr_q <= '0;
    end else begin
      op_q <= op_d;
      if (addr_en) addr_q <= addr_d;
    end
  end
endmodule

// File: rtl/ddr2b_pair_mem.sv
module ddr2b_pair_mem #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] w_first,
  input  logic [DW-1:0] w_second,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] r_first,
  output logic [DW-1:0] r_second
);
  localparam int ROWS = 1 << (AW - 1);

  logic [DW-1:0] lane_rd [2];

  for (genvar l = 0; l < 2; l++) begin : g_lane
    logic [DW-1:0] store [ROWS];
    logic [DW-1:0] wdat;

    always_comb wdat = (wa[0] == 1'(l)) ? w_first : w_second;

    always_ff @(posedge clk) begin
      if (we) store[wa[AW-1:1]] <= wdat;
    end

    always_comb lane_rd[l] = store[ra[AW-1:1]];
  end

  always_comb begin
    r_first  = lane_rd[ra[0]];
    r_second = lane_rd[~ra[0]];
  end
endmodule

// File: rtl/ddr2b_rd_pipe.sv
module ddr2b_rd_pipe #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_s,
  input  logic          rd_en,
  input  logic [DW-1:0] r_first,
  input  logic [DW-1:0] r_second,
  output logic [DW-1:0] q_rise,
  output logic [DW-1:0] q_fall,
  output logic          q_oe_rise,
  output logic          q_oe_fall,
  output logic          echo_ck
);
  logic [DW-1:0] rise_d, fall_d;
  logic          oe_d, echo_d;

  always_comb begin
    oe_d   = rd_en;
    rise_d = rd_en ? r_first  : '0;
    fall_d = rd_en ? r_second : '0;
    echo_d = !echo_ck;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      q_rise    <= '0;
      q_fall    <= '0;
      q_oe_rise <= 1'b0;
      q_oe_fall <= 1'b0;
      echo_ck   <= 1'b0;
    end else begin
      q_rise    <= rise_d;
      q_fall    <= fall_d;
      q_oe_rise <= oe_d;
      q_oe_fall <= oe_d;
      echo_ck   <= echo_d;
    end
  end
endmodule

// File: rtl/ddr2b_core.sv
module ddr2b_core
  import ddr2b_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_n,
  input  logic          rw_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wd_rise,
  input  logic [DW-1:0] wd_fall,
  output logic [DW-1:0] q_rise,
  output logic [DW-1:0] q_fall,
  output logic          q_oe_rise,
  output logic          q_oe_fall,
  output logic          echo_ck
);
  logic          rst_s;
  op_e           op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] r_first, r_second;
  logic          wr_en, rd_en;

  ddr2b_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_s(rst_s)
  );

  ddr2b_cmd_dec #(.AW(AW)) u_dec (
    .clk(clk), .rst_s(rst_s), .ld_n(ld_n), .rw_n(rw_n), .addr(addr),
    .op_q(op_q), .addr_q(addr_q)
  );

  always_comb begin
    wr_en = (op_q == OP_WR);
    rd_en = (op_q == OP_RD);
  end

  ddr2b_pair_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .we(wr_en), .wa(addr_q), .w_first(wd_rise), .w_second(wd_fall),
    .ra(addr_q), .r_first(r_first), .r_second(r_second)
  );

  ddr2b_rd_pipe #(.DW(DW)) u_rd (
    .clk(clk), .rst_s(rst_s), .rd_en(rd_en), .r_first(r_first), .r_second(r_second),
    .q_rise(q_rise), .q_fall(q_fall), .q_oe_rise(q_oe_rise), .q_oe_fall(q_oe_fall),
    .echo_ck(echo_ck)
  );
endmodule

// File: rtl/ddr2b_chk.sv
module ddr2b_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_s,
  input logic          ld_n,
  input logic          rw_n,
  input logic [DW-1:0] q_rise,
  input logic [DW-1:0] q_fall,
  input logic          q_oe_rise,
  input logic          q_oe_fall,
  input logic          echo_ck
);
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_s)
    (!ld_n && rw_n) |-> ##2 (q_oe_rise && q_oe_fall)); // R6
  AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_s)
    ld_n |-> ##2 (!q_oe_rise && !q_oe_fall)); // R2
  AST_WR_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_s)
    (!ld_n && !rw_n) |-> ##2 !q_oe_rise); // R3
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_s)
    !q_oe_rise |-> (q_rise == '0 && q_fall == '0)); // R7
  AST_B2B_STREAM: assert property (@(posedge clk) disable iff (!rst_s)
    (!ld_n && rw_n) ##1 (!ld_n && rw_n) |=> q_oe_rise ##1 q_oe_rise); // R8
  AST_ECHO_TOGGLE: assert property (@(posedge clk) disable iff (!rst_s)
    $past(rst_s) |-> (echo_ck != $past(echo_ck))); // R10
endmodule

bind ddr2b_core ddr2b_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_s(rst_s), .ld_n(ld_n), .rw_n(rw_n),
  .q_rise(q_rise), .q_fall(q_fall), .q_oe_rise(q_oe_rise), .q_oe_fall(q_oe_fall),
  .echo_ck(echo_ck)
);

// File: tb/ddr2b_core_bench.sv
module ddr2b_core_bench;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld_n = 1'b1, rw_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wd_rise = '0, wd_fall = '0;
  logic [DW-1:0] q_rise, q_fall;
  logic          q_oe_rise, q_oe_fall, echo_ck;

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] ref_mem [NW];
  // command issued one step ago, and the one before it
  int            p1_op = 0, p2_op = 0;   // 0 nop, 1 read, 2 write
  logic [AW-1:0] p1_a = '0, p2_a = '0;
  // expectation for the outputs at the next step
  logic          exp_oe = 1'b0;
  logic [DW-1:0] exp_r = '0, exp_f = '0;
  string         exp_tag = "R1";
  logic          last_echo = 1'b0;
  bit            echo_valid = 1'b0;

  always #5 clk = ~clk;

  ddr2b_core #(.AW(AW), .DW(DW)) u_ddr2b_core (
    .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .rw_n(rw_n), .addr(addr),
    .wd_rise(wd_rise), .wd_fall(wd_fall), .q_rise(q_rise), .q_fall(q_fall),
    .q_oe_rise(q_oe_rise), .q_oe_fall(q_oe_fall), .echo_ck(echo_ck)
  );

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    finish_run();
  end

  function automatic string tag_for(int op, int prev_op, logic [AW-1:0] a, logic [AW-1:0] pa);
    if (op != 1) return (prev_op == 0) ? "R2 R7" : "R3 R7";
    if (prev_op == 2 && pa[AW-1:1] == a[AW-1:1]) return "R9 R6";
    if (prev_op == 1) return "R8 R6";
    return a[0] ? "R4 odd R5 R6" : "R4 even R5 R6";
  endfunction

  // one falling edge: check, build next expectation, drive write data and new command
  task automatic step(int op, logic [AW-1:0] a);
    logic [DW-1:0] dr, df;
    @(negedge clk);
    checks++;
    if (q_oe_rise !== exp_oe || q_oe_fall !== exp_oe || q_rise !== exp_r || q_fall !== exp_f) begin
      errors++;
      $display("FAIL %s: actual oe=%b/%b rise=%h fall=%h expected oe=%b rise=%h fall=%h",
               exp_tag, q_oe_rise, q_oe_fall, q_rise, q_fall, exp_oe, exp_r, exp_f);
    end
    if (echo_valid) begin
      checks++;
      if (echo_ck === last_echo) begin
        errors++;
        $display("FAIL R10: echo actual=%b expected=%b", echo_ck, ~last_echo);
      end
    end
    last_echo = echo_ck;
    echo_valid = 1'b1;
    // expectation for the command issued one step ago
    exp_oe  = (p1_op == 1);
    exp_r   = exp_oe ? ref_mem[p1_a] : '0;
    exp_f   = exp_oe ? ref_mem[p1_a ^ AW'(1)] : '0;
    exp_tag = tag_for(p1_op, p2_op, p1_a, p2_a);
    // write data slot belongs to the command issued one step ago
    dr = DW'($urandom);
    df = DW'($urandom);
    wd_rise = dr;
    wd_fall = df;
    if (p1_op == 2) begin
      ref_mem[p1_a] = dr;
      ref_mem[p1_a ^ AW'(1)] = df;
    end
    // new command; junk on rw_n and addr for a nop
    ld_n = (op == 0);
    rw_n = (op == 0) ? 1'($urandom) : (op == 1);
    addr = (op == 0) ? AW'($urandom) : a;
    p2_op = p1_op; p2_a = p1_a;
    p1_op = op;    p1_a = a;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state while held
    checks++;
    if (q_oe_rise !== 1'b0 || q_oe_fall !== 1'b0 || q_rise !== '0 || q_fall !== '0 || echo_ck !== 1'b0) begin
      errors++;
      $display("FAIL R1: actual oe=%b/%b rise=%h fall=%h echo=%b expected 0/0 0 0 0",
               q_oe_rise, q_oe_fall, q_rise, q_fall, echo_ck);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // fill the whole memory, one burst per pair
    for (int i = 0; i < NW; i += 2) step(2, AW'(i));
    step(0, '0);
    // R4 odd and even starts
    step(2, AW'(5));
    step(1, AW'(5));
    step(1, AW'(4));
    step(0, '0);
    // R8 back-to-back reads
    for (int i = 0; i < 6; i++) step(1, AW'(i * 7));
    // R9 read straight after write, same pair, both orders
    step(2, AW'(10)); step(1, AW'(10));
    step(2, AW'(21)); step(1, AW'(20));
    // R2 nops with junk, then reads to show memory untouched
    for (int i = 0; i < 4; i++) step(0, '0);
    step(1, AW'(10)); step(1, AW'(21));
    for (int i = 0; i < 3; i++) step(0, '0);
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      int r = int'($urandom_range(0, 9));
      int op = (r < 2) ? 0 : (r < 6) ? 1 : 2;
      step(op, AW'($urandom));
    end
    for (int i = 0; i < 3; i++) step(0, '0);
    finish_run();
  end
endmodule